// File: doc/BRIEF.md
# Indexed Programmed-I/O Register Port

This block is the host-side slave through which a processor programs a small audio peripheral with plain register reads and writes. The host sees four direct registers: a pointer, a window onto an array of indirect control registers chosen by that pointer, a status byte, and a byte-wide audio data port. The indirect control registers are brought out flat so that the rest of the peripheral can use them.

A bus cycle counts only while chip select is high and both DMA acknowledges (capture and playback) are low. Read data is driven for as long as the host holds the read strobe low. A write takes effect when the write strobe returns high, using the address and data held during its low phase. Audio samples move through the data port one byte at a time, lowest byte first. The status byte shows which byte comes next. Once a whole sample has moved, the port stays closed until the host completes a status read. An audio access while the port is closed is dropped and recorded in a sticky error flag.

Top module: `pio_regport`

## Requirements
- R1: After reset the pointer reads 0, every indirect register is 0, and status reads 8'h10 (ready set, no error, next byte 0).
- R2: A strobe has effect only if chip select is 1 and `cdak` and `pdak` are both 0 in the last cycle of its low phase. Otherwise no register changes, and `rdata_oe` is 0 whenever either acknowledge is high.
- R3: `rdata_oe` is 1 and `rdata` carries the addressed register in every cycle in which `rd_n` is low in a qualified cycle. Otherwise `rdata_oe` is 0 and `rdata` is 0.
- R4: A write changes its target only on the cycle `wr_n` returns high, using the address and data of its last low cycle. During the low phase the target keeps its old value.
- R5: Address 0 is the pointer. It holds the low 5 bits of the written byte and reads back with its upper bits 0. Address 1 reads and writes the indirect register the pointer selects, which appears on `cfg_flat[8*i +: 8]`.
- R6: Address 2 is status, laid out as: bits [1:0] = index of the next audio byte, bit 4 = ready, bit 5 = sticky error, all other bits 0.
- R7: Writes to address 3 fill the playback sample lowest byte first. The write that completes the sample puts the whole sample on `play_sample` and raises `play_vld` for exactly one cycle, starting the cycle after that write takes effect.
- R8: Reads of address 3 return the bytes of `cap_sample`, lowest byte first, and the next-byte index advances after each read.
- R9: After the last byte of a sample, ready is 0 and the next-byte index is 0 until a status read completes. Status reads between bytes are allowed and change nothing.
- R10: An audio access while ready is 0 leaves the byte index and `play_vld` unchanged, reads 0, and sets the error bit. The error bit stays set through status reads and clears only on a status write with bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cdak | input | 1 | Capture DMA acknowledge, active high |
| pdak | input | 1 | Playback DMA acknowledge, active high |
| addr | input | 2 | Direct register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not driving |
| rdata_oe | output | 1 | Read data drive enable |
| cfg_flat | output | 256 | The 32 indirect registers, register i at bits 8*i+7 : 8*i |
| cap_sample | input | 32 | Capture sample presented for reading |
| play_sample | output | 32 | Last complete playback sample |
| play_vld | output | 1 | One-cycle pulse when a playback sample completes |

## Verification
Two things can land on the same clock edge: the trailing edge of a write strobe and a change in bus qualification. The bench holds `wr_n` low and raises `pdak` in the final low cycle, then releases the strobe. The write must be dropped, which is judged by reading the target back and by watching `cfg_flat`. A second case covers a sample whose last byte closes the port while the next access arrives before the status read. Here the bench checks at the ports that `play_vld` stays low, that the byte index does not move, and that the error flag survives the status read that reopens the port.

// File: rtl/pio_regport_pkg.sv
// Shared definitions for the indexed programmed-I/O register port.
// Assumes the direct register map below is fixed by the host software.
package pio_regport_pkg;

    typedef enum logic [1:0] {
        REG_INDEX  = 2'd0,
        REG_IDATA  = 2'd1,
        REG_STATUS = 2'd2,
        REG_AUDIO  = 2'd3
    } reg_sel_e;

    localparam int ST_READY_BIT = 4;
    localparam int ST_ERR_BIT   = 5;

endpackage

// File: rtl/pio_bus_front.sv
// Bus front end: qualifies host strobes and turns each strobe's trailing
// edge into a single-cycle commit carrying the address and data of the
// strobe's last low cycle. Assumes strobes are already synchronous to clk.
module pio_bus_front #(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cdak,
    input  logic          pdak,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_active,
    output logic          wr_commit,
    output logic          rd_commit,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data
);

    logic qual;
    logic wlow_q;
    logic rlow_q;

    assign qual      = cs & ~cdak & ~pdak;
    assign rd_active = ~rd_n & wr_n & qual;

    // Remember whether the previous cycle was a qualified strobe low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlow_q   <= 1'b0;
            rlow_q   <= 1'b0;
            cmt_addr <= '0;
            cmt_data <= '0;
        end else begin
            wlow_q   <= ~wr_n & rd_n & qual;
            rlow_q   <= ~rd_n & wr_n & qual;
            cmt_addr <= addr;
            cmt_data <= wdata;
        end
    end

    assign wr_commit = wlow_q & wr_n;
    assign rd_commit = rlow_q & rd_n;

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_commit && rd_commit)); // R4

    AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(!wr_n)); // R4

endmodule

// File: rtl/pio_ind_regs.sv
// Pointer register and the array of indirect control registers it selects.
// Assumes write enables are single-cycle commits from the bus front end.
module pio_ind_regs #(
    parameter int NUM_IND = 32,
    parameter int DW      = 8,
    localparam int IDX_W  = $clog2(NUM_IND)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_index,
    input  logic                  we_data,
    input  logic [DW-1:0]         wdata,
    output logic [IDX_W-1:0]      index,
    output logic [DW-1:0]         sel_data,
    output logic [NUM_IND*DW-1:0] cfg_flat
);

    logic [DW-1:0] regs [NUM_IND];

    // Pointer update on a committed write to the index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (we_index) begin
            index <= wdata[IDX_W-1:0];
        end
    end

    // Indirect register write through the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IND; i++) regs[i] <= '0;
        end else if (we_data) begin
            regs[index] <= wdata;
        end
    end

    assign sel_data = regs[index];

    for (genvar g = 0; g < NUM_IND; g++) begin : g_flat
        assign cfg_flat[g*DW +: DW] = regs[g];
    end

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_index |=> $stable(index)); // R5

    AST_SEL_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we_data && !we_index) |=> sel_data == $past(wdata)); // R5

endmodule

// File: rtl/pio_audio_seq.sv
// Byte sequencer for audio samples moved through the data register, with
// the status-read interlock and sticky error. Assumes at most one access
// commit per cycle and 1 to 4 bytes per sample.
module pio_audio_seq #(
    parameter int BPS    = 4,
    parameter int DW     = 8,
    localparam int CNT_W = (BPS > 1) ? $clog2(BPS) : 1,
    localparam int SW    = BPS * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr,
    input  logic             acc_rd,
    input  logic             stat_rd,
    input  logic             err_clr,
    input  logic [DW-1:0]    wdata,
    input  logic [SW-1:0]    cap_sample,
    output logic [DW-1:0]    cap_byte,
    output logic [CNT_W-1:0] next_byte,
    output logic             ready,
    output logic             err,
    output logic [SW-1:0]    play_sample,
    output logic             play_vld
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BPS - 1);

    logic [CNT_W-1:0] cnt;
    logic             locked;
    logic [SW-1:0]    pbuf;
    logic [SW-1:0]    pbuf_nxt;
    logic             access;

    assign access = acc_wr | acc_rd;

    // Merge the incoming byte into the partially built playback sample.
    always_comb begin
        pbuf_nxt = pbuf;
        for (int i = 0; i < BPS; i++) begin
            if (CNT_W'(i) == cnt) pbuf_nxt[i*DW +: DW] = wdata;
        end
    end

    // Byte index, interlock and sample assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt         <= '0;
            locked      <= 1'b0;
            pbuf        <= '0;
            play_sample <= '0;
            play_vld    <= 1'b0;
        end else begin
            play_vld <= 1'b0;
            if (access && !locked) begin
                if (acc_wr) pbuf <= pbuf_nxt;
                if (cnt == LAST) begin
                    cnt    <= '0;
                    locked <= 1'b1;
                    if (acc_wr) begin
                        play_sample <= pbuf_nxt;
                        play_vld    <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (stat_rd) begin
                locked <= 1'b0;
            end
        end
    end

    // Sticky error: set by an access while closed, cleared by request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (access && locked) begin
            err <= 1'b1;
        end else if (err_clr) begin
            err <= 1'b0;
        end
    end

    assign cap_byte  = locked ? '0 : cap_sample[int'(cnt)*DW +: DW];
    assign next_byte = cnt;
    assign ready     = ~locked;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R7

    AST_LOCK_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (access && ready && next_byte == LAST) |=> !ready); // R9

    AST_LOCKED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ready) |=> err); // R10

    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !ready) |=> ($stable(next_byte) && !play_vld)); // R10

    AST_VLD_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        play_vld |-> !ready); // R7

endmodule

// File: rtl/pio_regport.sv
// Top of the indexed programmed-I/O register port: four direct registers
// (pointer, indirect window, status, audio data) behind a qualified host bus.
// Assumes host strobes are synchronous to clk and never low together.
module pio_regport #(
    parameter int NUM_IND = 32,
    parameter int BPS     = 4,
    localparam int DW     = 8,
    localparam int SW     = BPS * DW,
    localparam int CNT_W  = (BPS > 1) ? $clog2(BPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  cdak,
    input  logic                  pdak,
    input  logic [1:0]            addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic                  rdata_oe,
    output logic [NUM_IND*DW-1:0] cfg_flat,
    input  logic [SW-1:0]         cap_sample,
    output logic [SW-1:0]         play_sample,
    output logic                  play_vld
);
    import pio_regport_pkg::*;

    localparam int IDX_W = $clog2(NUM_IND);

    logic             rd_active;
    logic             wr_commit;
    logic             rd_commit;
    logic [1:0]       cmt_addr;
    logic [DW-1:0]    cmt_data;
    logic [IDX_W-1:0] index;
    logic [DW-1:0]    sel_data;
    logic [DW-1:0]    cap_byte;
    logic [CNT_W-1:0] next_byte;
    logic             ready;
    logic             err;
    logic [DW-1:0]    status;
    logic [DW-1:0]    mux_out;

    pio_bus_front #(.AW(2), .DW(DW)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cdak      (cdak),
        .pdak      (pdak),
        .addr      (addr),
        .wdata     (wdata),
        .rd_active (rd_active),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data)
    );

    pio_ind_regs #(.NUM_IND(NUM_IND), .DW(DW)) u_ind (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_index (wr_commit && cmt_addr == REG_INDEX),
        .we_data  (wr_commit && cmt_addr == REG_IDATA),
        .wdata    (cmt_data),
        .index    (index),
        .sel_data (sel_data),
        .cfg_flat (cfg_flat)
    );

    pio_audio_seq #(.BPS(BPS), .DW(DW)) u_audio (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr      (wr_commit && cmt_addr == REG_AUDIO),
        .acc_rd      (rd_commit && cmt_addr == REG_AUDIO),
        .stat_rd     (rd_commit && cmt_addr == REG_STATUS),
        .err_clr     (wr_commit && cmt_addr == REG_STATUS && cmt_data[ST_ERR_BIT]),
        .wdata       (cmt_data),
        .cap_sample  (cap_sample),
        .cap_byte    (cap_byte),
        .next_byte   (next_byte),
        .ready       (ready),
        .err         (err),
        .play_sample (play_sample),
        .play_vld    (play_vld)
    );

    // Assemble the status byte from the sequencer state.
    always_comb begin
        status                 = '0;
        status[CNT_W-1:0]      = next_byte;
        status[ST_READY_BIT]   = ready;
        status[ST_ERR_BIT]     = err;
    end

    // Select the register addressed by the current read.
    always_comb begin
        case (addr)
            REG_INDEX:  mux_out = DW'(index);
            REG_IDATA:  mux_out = sel_data;
            REG_STATUS: mux_out = status;
            default:    mux_out = cap_byte;
        endcase
    end

    assign rdata_oe = rd_active;
    assign rdata    = rd_active ? mux_out : '0;

    AST_NO_DRIVE_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (cdak || pdak) |-> !rdata_oe); // R2

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> rdata == '0); // R3

    AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!rd_n && cs)); // R3

endmodule

// File: tb/pio_regport_bench.sv
// Directed bench for the indexed programmed-I/O register port.
module pio_regport_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0;
    logic         rd_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         cdak = 1'b0;
    logic         pdak = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [7:0]   wdata = 8'd0;
    logic [7:0]   rdata;
    logic         rdata_oe;
    logic [255:0] cfg_flat;
    logic [31:0]  cap_sample = 32'd0;
    logic [31:0]  play_sample;
    logic         play_vld;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    pio_regport u_pio_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs          (cs),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .cdak        (cdak),
        .pdak        (pdak),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .rdata_oe    (rdata_oe),
        .cfg_flat    (cfg_flat),
        .cap_sample  (cap_sample),
        .play_sample (play_sample),
        .play_vld    (play_vld)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1'b1; addr = a; wdata = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1'b1; addr = a; rd_n = 1'b0;
        @(negedge clk); d = rdata; rd_n = 1'b1;
        @(negedge clk); cs = 1'b0;
    endtask

    // R1 and R6: state straight after reset.
    task automatic t_reset();
        bus_read(2'd2, rv); chk(rv == 8'h10, "R1 status", rv, 8'h10);
        bus_read(2'd0, rv); chk(rv == 8'h00, "R1 index", rv, 8'h00);
        chk(cfg_flat == '0, "R1 cfg", cfg_flat[31:0], 0);
    endtask

    // R5: pointer width and indirect window.
    task automatic t_index();
        bus_write(2'd0, 8'd5); bus_write(2'd1, 8'hA5);
        bus_read(2'd1, rv); chk(rv == 8'hA5, "R5 window read", rv, 8'hA5);
        chk(cfg_flat[5*8 +: 8] == 8'hA5, "R5 cfg slot 5", cfg_flat[5*8 +: 8], 8'hA5);
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, rv); chk(rv == 8'h1F, "R5 pointer mask", rv, 8'h1F);
        bus_write(2'd1, 8'h77);
        chk(cfg_flat[31*8 +: 8] == 8'h77, "R5 cfg slot 31", cfg_flat[31*8 +: 8], 8'h77);
        chk(cfg_flat[5*8 +: 8] == 8'hA5, "R5 slot 5 kept", cfg_flat[5*8 +: 8], 8'hA5);
    endtask

    // R2: unqualified cycles, including a DMA acknowledge in the last low cycle.
    task automatic t_qualify();
        bus_write(2'd0, 8'd3);
        @(negedge clk); cs = 1'b0; addr = 2'd1; wdata = 8'h99; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        chk(cfg_flat[3*8 +: 8] == 8'h00, "R2 no cs", cfg_flat[3*8 +: 8], 0);
        @(negedge clk); cs = 1'b1; addr = 2'd1; wdata = 8'h66; wr_n = 1'b0;
        @(negedge clk); pdak = 1'b1;
        @(negedge clk); wr_n = 1'b1; pdak = 1'b0;
        @(negedge clk); cs = 1'b0;
        chk(cfg_flat[3*8 +: 8] == 8'h00, "R2 pdak at edge", cfg_flat[3*8 +: 8], 0);
        @(negedge clk); cs = 1'b1; addr = 2'd0; rd_n = 1'b0; cdak = 1'b1;
        @(negedge clk);
        chk(rdata_oe == 1'b0, "R2 no drive in cdak", rdata_oe, 0);
        rd_n = 1'b1; cdak = 1'b0;
        @(negedge clk); cs = 1'b0;
        bus_read(2'd1, rv); chk(rv == 8'h00, "R2 readback", rv, 0);
    endtask

    // R4: target holds through the low phase and changes at the release.
    task automatic t_write_edge();
        @(negedge clk); cs = 1'b1; addr = 2'd1; wdata = 8'h5A; wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(cfg_flat[3*8 +: 8] == 8'h00, "R4 held while low", cfg_flat[3*8 +: 8], 0);
        wdata = 8'hC3;
        @(negedge clk); wr_n = 1'b1; wdata = 8'h00;
        @(negedge clk); cs = 1'b0;
        chk(cfg_flat[3*8 +: 8] == 8'hC3, "R4 last low data", cfg_flat[3*8 +: 8], 8'hC3);
    endtask

    // R3: drive while the read strobe is low, quiet afterwards.
    task automatic t_read_drive();
        @(negedge clk); cs = 1'b1; addr = 2'd0; rd_n = 1'b0;
        @(negedge clk);
        chk(rdata_oe && rdata == 8'h03, "R3 drive cycle 1", {rdata_oe, rdata}, 9'h103);
        @(negedge clk);
        chk(rdata_oe && rdata == 8'h03, "R3 drive cycle 2", {rdata_oe, rdata}, 9'h103);
        rd_n = 1'b1;
        @(negedge clk);
        chk(!rdata_oe && rdata == 8'h00, "R3 released", {rdata_oe, rdata}, 0);
        cs = 1'b0;
    endtask

    // R7 and R9: a full playback sample with a status read between bytes.
    task automatic t_play();
        bus_write(2'd3, 8'h11);
        bus_read(2'd2, rv); chk(rv == 8'h11, "R9 mid-sample status", rv, 8'h11);
        bus_write(2'd3, 8'h22);
        bus_write(2'd3, 8'h33);
        chk(play_vld == 1'b0, "R7 no early pulse", play_vld, 0);
        bus_write(2'd3, 8'h44);
        chk(play_vld == 1'b1, "R7 pulse", play_vld, 1);
        chk(play_sample == 32'h44332211, "R7 sample order", play_sample, 32'h44332211);
        @(negedge clk);
        chk(play_vld == 1'b0, "R7 pulse one cycle", play_vld, 0);
        bus_read(2'd2, rv); chk(rv == 8'h00, "R9 closed", rv, 8'h00);
        bus_read(2'd2, rv); chk(rv == 8'h10, "R9 reopened", rv, 8'h10);
    endtask

    // R10: access while closed is dropped and sets the sticky error.
    task automatic t_locked();
        bus_write(2'd3, 8'hAA); bus_write(2'd3, 8'hBB);
        bus_write(2'd3, 8'hCC); bus_write(2'd3, 8'hDD);
        bus_write(2'd3, 8'hEE);
        chk(play_vld == 1'b0, "R10 no pulse", play_vld, 0);
        chk(play_sample == 32'hDDCCBBAA, "R10 sample kept", play_sample, 32'hDDCCBBAA);
        bus_read(2'd3, rv); chk(rv == 8'h00, "R10 read zero", rv, 0);
        bus_read(2'd2, rv); chk(rv == 8'h20, "R10 error and index", rv, 8'h20);
        bus_read(2'd2, rv); chk(rv == 8'h30, "R10 sticky", rv, 8'h30);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, rv); chk(rv == 8'h30, "R10 no clear without bit", rv, 8'h30);
        bus_write(2'd2, 8'h20);
        bus_read(2'd2, rv); chk(rv == 8'h10, "R10 cleared", rv, 8'h10);
    endtask

    // R8: capture bytes read lowest first.
    task automatic t_capture();
        cap_sample = 32'hDEADBEEF;
        bus_read(2'd3, rv); chk(rv == 8'hEF, "R8 byte 0", rv, 8'hEF);
        bus_read(2'd2, rv); chk(rv == 8'h11, "R8 index 1", rv, 8'h11);
        bus_read(2'd3, rv); chk(rv == 8'hBE, "R8 byte 1", rv, 8'hBE);
        bus_read(2'd3, rv); chk(rv == 8'hAD, "R8 byte 2", rv, 8'hAD);
        bus_read(2'd3, rv); chk(rv == 8'hDE, "R8 byte 3", rv, 8'hDE);
        bus_read(2'd2, rv); chk(rv == 8'h00, "R9 closed after capture", rv, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_qualify();
        t_write_edge();
        t_read_drive();
        t_play();
        t_locked();
        t_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule